// File: doc/BRIEF.md
# Byte-Granular Vector Extract Unit

This block executes one SIMD extract operation per accepted instruction word. It holds a bank of 32 doubleword (64-bit) vector registers. A quadword (128-bit) register is an aligned even/odd pair in that bank, with the even register holding the low half. The operation treats both sources as strings of 8-bit lanes and ignores any data type. It starts at a byte offset inside the first source and takes bytes from there up to that source's top byte. The free upper lanes of the result are then filled, lowest first, with the lowest bytes of the second source. Bit 6 of the word picks a 64-bit or a 128-bit operation.

The instruction word is presented on `issue_word` with `issue_valid`. A word whose fixed bits do not match is ignored. A matching word whose fields are illegal for its width raises `undef_flag` and writes nothing. A legal word updates the destination at the same clock edge that accepts it, and `wb_valid` reports this in the following cycle. The register bank is loaded through a fill port and can be read at any time through a combinational observe port.

Top module: `vext_unit`

## Requirements
- R1: A word is decoded only when bits 31..23 equal 111011111, bits 21..20 equal 11 and bit 4 equals 0. Any other word leaves every register unchanged and raises neither `wb_valid` nor `undef_flag`.
- R2: The destination number is {bit 22, bits 15..12}. The first source is {bit 7, bits 19..16}. The second source is {bit 5, bits 3..0}. The byte offset is bits 11..8, and bit 6 set selects the 128-bit width.
- R3: In 64-bit mode with offset k (0..7), result byte j equals first-source byte j+k when j+k < 8, and second-source byte j+k-8 otherwise. Only the 64-bit destination register is written.
- R4: In 128-bit mode with offset k (0..15), the operands are register pairs. Result byte j equals first-pair byte j+k when j+k < 16, and second-pair byte j+k-16 otherwise. The low 64 bits go to the even destination register and the high 64 bits to the next odd register.
- R5: An offset of zero writes the first source to the destination unchanged, in either width.
- R6: In 64-bit mode, an offset with bit 3 set raises `undef_flag` and suppresses the write.
- R7: In 128-bit mode, an odd destination, first-source or second-source number raises `undef_flag` and suppresses the write.
- R8: `wb_valid` or `undef_flag` is high for exactly the one cycle after the accepting edge. The written value is visible on `obs_data` after that edge.
- R9: The sources are read before the write, so a destination that overlaps a source still receives the correct result.
- R10: After reset, every register reads zero and both flags are low.
- R11: `fill_en` writes `fill_data` to register `fill_idx` at the clock edge. If a result write targets the same register at the same edge, the result wins.
- R12: `wb_valid` and `undef_flag` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word present this cycle |
| issue_word | input | 32 | Instruction word |
| fill_en | input | 1 | Load one register from the fill port |
| fill_idx | input | 5 | Register loaded by the fill port |
| fill_data | input | 64 | Value loaded by the fill port |
| obs_idx | input | 5 | Register shown on the observe port |
| obs_data | output | 64 | Current value of register `obs_idx` |
| wb_valid | output | 1 | A result was written at the previous edge |
| undef_flag | output | 1 | An illegal matching word was rejected at the previous edge |

## Verification
The bench sweeps every offset in both widths against a model that shifts the concatenated sources. A lane selection error or a swapped source order shows up as misplaced bytes. Offsets 0 and 15 catch off-by-one mistakes at the ends, and offsets 8 to 15 in 64-bit mode must be rejected; a design that let them through would write wrapped garbage. It drives odd register numbers in 128-bit mode one operand at a time, word bits the decoder must refuse, high-half register numbers that need the extra number bits, overlapping destinations that a late read would corrupt, and a fill that collides with a result write.

// File: rtl/vext_pkg.sv
package vext_pkg;

   // Fixed instruction geometry
   localparam int INSN_W     = 32;
   localparam int RNUM_W     = 5;
   localparam int OFFSET_W   = 4;

   // Opcode constants that must match for a word to be decoded
   localparam logic [8:0] OPC_TOP = 9'b111011111;
   localparam logic [1:0] OPC_MID = 2'b11;
   localparam logic       OPC_LOW = 1'b0;

   typedef struct packed {
      logic                match;
      logic                quad;
      logic [RNUM_W-1:0]   rd;
      logic [RNUM_W-1:0]   rn;
      logic [RNUM_W-1:0]   rm;
      logic [OFFSET_W-1:0] offset;
      logic                illegal;
   } vext_op_t;

endpackage

// File: rtl/vext_decode.sv
module vext_decode
   import vext_pkg::*;
(
   input  logic [INSN_W-1:0] word,
   output vext_op_t          op
);

   logic is_match;
   logic wide;
   logic odd_any;

   always_comb begin
      is_match = (word[31:23] == OPC_TOP) && (word[21:20] == OPC_MID) &&
                 (word[4] == OPC_LOW);
      wide     = word[6];

      op.match  = is_match;
      op.quad   = wide;
      op.rd     = {word[22], word[15:12]};
      op.rn     = {word[7],  word[19:16]};
      op.rm     = {word[5],  word[3:0]};
      op.offset = word[11:8];

      // 128-bit operands name register pairs: every number must be even
      odd_any = word[12] | word[16] | word[0];
      // 64-bit operands hold 8 lanes: offset must stay below 8
      op.illegal = wide ? odd_any : word[11];
   end

endmodule

// File: rtl/vext_funnel.sv
module vext_funnel
   import vext_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int DREG_W = 64
) (
   input  logic                  quad,
   input  logic [OFFSET_W-1:0]   offset,
   input  logic [2*DREG_W-1:0]   first,
   input  logic [2*DREG_W-1:0]   second,
   output logic [2*DREG_W-1:0]   result
);

   localparam int BYTES = DREG_W / LANE_W;
   localparam int LANES = 2 * BYTES;
   localparam int LI_W  = $clog2(LANES);
   localparam int SEL_W = $clog2(2 * LANES);

   if (DREG_W % LANE_W != 0) begin : g_chk_div
      $error("vext_funnel: DREG_W must be a multiple of LANE_W");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_chk_pow2
      $error("vext_funnel: lane count must be a power of two");
   end
   if (LANES > (1 << OFFSET_W)) begin : g_chk_off
      $error("vext_funnel: offset field too narrow for lane count");
   end

   logic [LANE_W-1:0] fl [LANES];
   logic [LANE_W-1:0] sl [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_unpack
      assign fl[k] = first [k*LANE_W +: LANE_W];
      assign sl[k] = second[k*LANE_W +: LANE_W];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [SEL_W:0] sel;
      logic [SEL_W:0] half_off;
      logic [LANE_W-1:0] q_byte;
      logic [LANE_W-1:0] d_byte;

      always_comb begin
         sel      = (SEL_W+1)'(j) + (SEL_W+1)'(offset);
         half_off = sel - (SEL_W+1)'(BYTES);
         // 128-bit: lane index wraps into the second pair past LANES
         q_byte = sel[LI_W] ? sl[sel[LI_W-1:0]] : fl[sel[LI_W-1:0]];
         // 64-bit: only the low BYTES of each source take part
         if (sel < (SEL_W+1)'(BYTES)) begin
            d_byte = fl[sel[LI_W-1:0]];
         end else begin
            d_byte = sl[half_off[LI_W-1:0]];
         end
      end

      if (j < BYTES) begin : g_low
         assign result[j*LANE_W +: LANE_W] = quad ? q_byte : d_byte;
      end else begin : g_high
         assign result[j*LANE_W +: LANE_W] = quad ? q_byte : '0;
      end
   end

endmodule

// File: rtl/vext_regfile.sv
module vext_regfile
   import vext_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int DREG_W = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(NREG)-1:0]     rd_idx [4],
   output logic [DREG_W-1:0]           rd_dat [4],
   input  logic [$clog2(NREG)-1:0]     obs_idx,
   output logic [DREG_W-1:0]           obs_dat,
   input  logic                        fill_en,
   input  logic [$clog2(NREG)-1:0]     fill_idx,
   input  logic [DREG_W-1:0]           fill_dat,
   input  logic                        wb_lo_en,
   input  logic                        wb_hi_en,
   input  logic [$clog2(NREG)-1:0]     wb_idx,
   input  logic [DREG_W-1:0]           wb_lo_dat,
   input  logic [DREG_W-1:0]           wb_hi_dat
);

   localparam int IDX_W = $clog2(NREG);

   if (NREG != (1 << RNUM_W)) begin : g_chk_nreg
      $error("vext_regfile: NREG must match the register number field");
   end

   logic [DREG_W-1:0] regs [NREG];
   logic [IDX_W-1:0]  wb_idx_odd;

   assign wb_idx_odd = wb_idx | IDX_W'(1);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[r] <= '0;
         end else if (wb_lo_en && (wb_idx == IDX_W'(r))) begin
            regs[r] <= wb_lo_dat;
         end else if (wb_hi_en && (wb_idx_odd == IDX_W'(r))) begin
            regs[r] <= wb_hi_dat;
         end else if (fill_en && (fill_idx == IDX_W'(r))) begin
            regs[r] <= fill_dat;
         end
      end
   end

   for (genvar p = 0; p < 4; p++) begin : g_rd
      assign rd_dat[p] = regs[rd_idx[p]];
   end

   assign obs_dat = regs[obs_idx];

   // R4: an upper-half write only comes with a lower-half write to an even pair
   a_r4_pair_even : assert property (@(posedge clk) disable iff (!rst_n)
      wb_hi_en |-> (wb_lo_en && !wb_idx[0]));

   // R11: result write beats a fill aimed at the same register
   a_r11_wb_over_fill : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_lo_en && fill_en && (fill_idx == wb_idx))
      |=> (regs[$past(wb_idx)] == $past(wb_lo_dat)));

endmodule

// File: rtl/vext_unit.sv
module vext_unit
   import vext_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int DREG_W = 64,
   parameter int NREG   = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue_valid,
   input  logic [INSN_W-1:0]         issue_word,
   input  logic                      fill_en,
   input  logic [RNUM_W-1:0]         fill_idx,
   input  logic [DREG_W-1:0]         fill_data,
   input  logic [RNUM_W-1:0]         obs_idx,
   output logic [DREG_W-1:0]         obs_data,
   output logic                      wb_valid,
   output logic                      undef_flag
);

   localparam int IDX_W = $clog2(NREG);

   if (IDX_W != RNUM_W) begin : g_chk_idx
      $error("vext_unit: register index width must match instruction fields");
   end

   vext_op_t op;
   logic                fire;
   logic                wb_lo_en;
   logic                wb_hi_en;
   logic [IDX_W-1:0]    rd_idx [4];
   logic [DREG_W-1:0]   rd_dat [4];
   logic [2*DREG_W-1:0] src_first;
   logic [2*DREG_W-1:0] src_second;
   logic [2*DREG_W-1:0] res;

   vext_decode u_dec (
      .word (issue_word),
      .op   (op)
   );

   // Read order: first low, first high, second low, second high
   assign rd_idx[0] = op.rn;
   assign rd_idx[1] = op.rn | IDX_W'(1);
   assign rd_idx[2] = op.rm;
   assign rd_idx[3] = op.rm | IDX_W'(1);

   assign src_first  = {rd_dat[1], rd_dat[0]};
   assign src_second = {rd_dat[3], rd_dat[2]};

   vext_funnel #(
      .LANE_W (LANE_W),
      .DREG_W (DREG_W)
   ) u_fun (
      .quad   (op.quad),
      .offset (op.offset),
      .first  (src_first),
      .second (src_second),
      .result (res)
   );

   assign fire     = issue_valid && op.match;
   assign wb_lo_en = fire && !op.illegal;
   assign wb_hi_en = wb_lo_en && op.quad;

   vext_regfile #(
      .NREG   (NREG),
      .DREG_W (DREG_W)
   ) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .rd_dat    (rd_dat),
      .obs_idx   (obs_idx),
      .obs_dat   (obs_data),
      .fill_en   (fill_en),
      .fill_idx  (fill_idx),
      .fill_dat  (fill_data),
      .wb_lo_en  (wb_lo_en),
      .wb_hi_en  (wb_hi_en),
      .wb_idx    (op.rd),
      .wb_lo_dat (res[DREG_W-1:0]),
      .wb_hi_dat (res[2*DREG_W-1:DREG_W])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid   <= 1'b0;
         undef_flag <= 1'b0;
      end else begin
         wb_valid   <= wb_lo_en;
         undef_flag <= fire && op.illegal;
      end
   end

   // R12: the two status pulses exclude each other
   a_r12_flags_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && undef_flag));

   // R8: any status pulse traces back to an issued word one cycle earlier
   a_r8_pulse_after_issue : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid || undef_flag) |-> $past(issue_valid));

   // R1: a word with a wrong fixed pattern produces no status at all
   a_r1_ignore_nonmatch : assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !op.match) |=> (!wb_valid && !undef_flag));

   // R6: a wide offset in 64-bit mode is rejected
   a_r6_dword_wide_offset : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !op.quad && op.offset[3]) |=> (undef_flag && !wb_valid));

   // R7: odd numbers in 128-bit mode are rejected
   a_r7_qword_odd_reg : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op.quad && (op.rd[0] || op.rn[0] || op.rm[0]))
      |=> (undef_flag && !wb_valid));

   // R5: zero offset passes the first source straight through
   a_r5_zero_offset : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_lo_en && (op.offset == '0)) |-> (res[DREG_W-1:0] == rd_dat[0]));

endmodule

// File: tb/vext_unit_tb.sv
module vext_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [31:0] issue_word = '0;
   logic        fill_en = 1'b0;
   logic [4:0]  fill_idx = '0;
   logic [63:0] fill_data = '0;
   logic [4:0]  obs_idx = '0;
   logic [63:0] obs_data;
   logic        wb_valid;
   logic        undef_flag;

   int checks = 0;
   int failures = 0;
   logic [63:0] mdl [32];

   always #10 clk = ~clk;

   vext_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_word  (issue_word),
      .fill_en     (fill_en),
      .fill_idx    (fill_idx),
      .fill_data   (fill_data),
      .obs_idx     (obs_idx),
      .obs_data    (obs_data),
      .wb_valid    (wb_valid),
      .undef_flag  (undef_flag)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(input logic [4:0] d, input logic [4:0] n,
                                       input logic [4:0] m, input logic [3:0] k,
                                       input logic q);
      return {9'b111011111, d[4], 2'b11, n[3:0], d[3:0], k, n[4], q, m[4], 1'b0, m[3:0]};
   endfunction

   task automatic read_reg(input int idx, output logic [63:0] v);
      obs_idx = 5'(idx);
      #1;
      v = obs_data;
   endtask

   task automatic compare_all(input string tag);
      logic [63:0] v;
      for (int r = 0; r < 32; r++) begin
         read_reg(r, v);
         chk(tag, v, mdl[r]);
      end
   endtask

   // Issue one word; returns flags sampled in the cycle after the edge (R8)
   task automatic run_word(input logic [31:0] w, input string tag,
                           input logic exp_wb, input logic exp_ud);
      @(negedge clk);
      issue_word  = w;
      issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      chk({tag, " R8 wb_valid pulse"}, 64'(wb_valid), 64'(exp_wb));
      chk({tag, " R8 undef pulse"}, 64'(undef_flag), 64'(exp_ud));
      @(negedge clk);
      chk({tag, " R8 pulse ends"}, 64'({wb_valid, undef_flag}), 64'(0));
   endtask

   // Issue an extract, update the model from the requirements, compare
   task automatic do_ext(input logic [4:0] d, input logic [4:0] n, input logic [4:0] m,
                         input logic [3:0] k, input logic q, input string tag);
      logic [255:0] cat;
      logic [127:0] qres;
      logic [127:0] dcat;
      logic [63:0]  dres;
      logic         bad;
      bad = q ? (d[0] | n[0] | m[0]) : k[3];
      cat  = {mdl[m | 5'd1], mdl[m], mdl[n | 5'd1], mdl[n]} >> (8 * k);
      qres = cat[127:0];
      dcat = {mdl[m], mdl[n]} >> (8 * k);
      dres = dcat[63:0];
      run_word(enc(d, n, m, k, q), tag, !bad, bad);
      if (!bad) begin
         if (q) begin
            mdl[d]         = qres[63:0];
            mdl[d | 5'd1]  = qres[127:64];
         end else begin
            mdl[d] = dres;
         end
      end
      compare_all(tag);
   endtask

   task automatic fill(input int idx, input logic [63:0] v);
      @(negedge clk);
      fill_en   = 1'b1;
      fill_idx  = 5'(idx);
      fill_data = v;
      @(negedge clk);
      fill_en = 1'b0;
      mdl[idx] = v;
   endtask

   task automatic t_reset;
      chk("R10 wb_valid after reset", 64'(wb_valid), 64'(0));
      chk("R10 undef after reset", 64'(undef_flag), 64'(0));
      for (int r = 0; r < 32; r++) mdl[r] = '0;
      compare_all("R10 register cleared");
   endtask

   task automatic t_load;
      for (int r = 0; r < 32; r++) begin
         logic [63:0] v;
         for (int b = 0; b < 8; b++) v[8*b +: 8] = 8'((r << 3) | b) ^ 8'h5a;
         fill(r, v);
      end
      compare_all("R11 fill loads register");
   endtask

   task automatic t_dword_sweep;
      for (int k = 0; k < 8; k++) begin
         do_ext(5'd10, 5'd3, 5'd7, 4'(k), 1'b0, k == 0 ? "R5 R3 dword offset" : "R3 dword offset");
         fill(10, 64'h0123_4567_89ab_cdef ^ 64'(k));
      end
   endtask

   task automatic t_qword_sweep;
      for (int k = 0; k < 16; k++) begin
         do_ext(5'd12, 5'd4, 5'd8, 4'(k), 1'b1, k == 0 ? "R5 R4 qword offset" : "R4 qword offset");
      end
   endtask

   task automatic t_dword_wide;
      for (int k = 8; k < 16; k++) do_ext(5'd14, 5'd1, 5'd2, 4'(k), 1'b0, "R6 dword wide offset");
   endtask

   task automatic t_qword_odd;
      do_ext(5'd13, 5'd4, 5'd8, 4'd3, 1'b1, "R7 odd destination");
      do_ext(5'd12, 5'd5, 5'd8, 4'd3, 1'b1, "R7 odd first source");
      do_ext(5'd12, 5'd4, 5'd9, 4'd3, 1'b1, "R7 odd second source");
   endtask

   task automatic t_nonmatch;
      logic [31:0] w;
      w = enc(5'd20, 5'd1, 5'd2, 4'd1, 1'b0);
      run_word(w ^ 32'h0080_0000, "R1 bit 23 flipped", 1'b0, 1'b0);
      compare_all("R1 bit 23 flipped");
      run_word(w ^ 32'h0000_0010, "R1 bit 4 set", 1'b0, 1'b0);
      compare_all("R1 bit 4 set");
      run_word(w ^ 32'h0010_0000, "R1 bit 20 cleared", 1'b0, 1'b0);
      compare_all("R1 bit 20 cleared");
      run_word(w ^ 32'h8000_0000, "R1 bit 31 cleared", 1'b0, 1'b0);
      compare_all("R1 bit 31 cleared");
   endtask

   task automatic t_fields;
      do_ext(5'd22, 5'd17, 5'd29, 4'd5, 1'b0, "R2 high numbers dword");
      do_ext(5'd18, 5'd20, 5'd30, 4'd11, 1'b1, "R2 high numbers qword");
   endtask

   task automatic t_overlap;
      do_ext(5'd6, 5'd6, 5'd9, 4'd2, 1'b0, "R9 dest equals first");
      do_ext(5'd24, 5'd16, 5'd24, 4'd9, 1'b1, "R9 dest equals second pair");
      do_ext(5'd26, 5'd26, 5'd26, 4'd4, 1'b1, "R9 all operands same pair");
   endtask

   task automatic t_collide;
      logic [127:0] dcat;
      dcat = {mdl[2], mdl[1]} >> 24;
      @(negedge clk);
      issue_word  = enc(5'd11, 5'd1, 5'd2, 4'd3, 1'b0);
      issue_valid = 1'b1;
      fill_en     = 1'b1;
      fill_idx    = 5'd11;
      fill_data   = 64'hdead_beef_dead_beef;
      @(negedge clk);
      issue_valid = 1'b0;
      fill_en     = 1'b0;
      mdl[11] = dcat[63:0];
      chk("R11 collision wb_valid", 64'(wb_valid), 64'(1));
      compare_all("R11 result beats fill");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_dword_sweep();
      t_qword_sweep();
      t_dword_wide();
      t_qword_odd();
      t_nonmatch();
      t_fields();
      t_overlap();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule